// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the byte returned on a read from a two-bank flash array while an internal program or erase algorithm is running, has exceeded its time limit, or has been suspended. Reads aimed at the bank that runs the algorithm get a status byte: a polling bit, a toggle bit that inverts on every status read, a timeout bit, an erase-window bit and a sector toggle bit that depends on the address. Reads aimed at the other bank, or made while nothing is running, get the array data that the caller supplies with the request.

A read request is one valid/ready transfer that carries bank, sector and array data. The response leaves through a one-entry output slot with its own valid/ready pair. The slot takes a new request when it is empty or is being emptied in the same cycle (`req_ready = !rsp_valid || rsp_ready`). So a stalled consumer back-pressures the requester, and no request is lost or read twice. The toggle state advances only when a request is accepted, which gives at most one step per read access. The mode inputs (program busy, erase busy, erase suspended, timeout, busy bank, erase-selected sectors, window closed) are plain level signals that the algorithm sequencer drives.

Top module: `esg_status_gen`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request produces `rsp_valid` on the next clock. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R2: A read whose bank differs from `busy_bank`, or a read made while program busy, erase busy and erase suspended are all low, returns `req_array` unchanged. After an algorithm completes, reads therefore return the stored (true) data.
- R3: With `op_prog_busy` high, a busy-bank read returns bit 7 = inverse of `last_wr_msb`, bit 6 = toggle bit, bit 5 = `op_timeout`, and all other bits 0.
- R4: With `op_erase_busy` high and program not busy, a busy-bank read returns bit 7 = 0, bit 6 = toggle bit, bit 5 = `op_timeout`, bit 3 = `erase_win_closed`, bit 2 = sector toggle bit, and all other bits 0.
- R5: The bit-6 toggle inverts once per accepted busy-bank read while program or erase is busy. It does not change on idle-bank reads, on suspend-mode reads, or in cycles with no accepted read.
- R6: The bit-2 toggle inverts once per accepted busy-bank read whose sector has its bit set in `erase_sel`, during erase busy or erase suspend with program not busy. Reads of unselected sectors leave it unchanged.
- R7: With only `op_erase_susp` high, a busy-bank read of a selected sector returns bit 7 = 1, bit 6 = the held toggle value, bit 2 = sector toggle, and all other bits 0. A busy-bank read of an unselected sector returns `req_array`.
- R8: Both toggles clear to 0 on a rising edge of `op_prog_busy`, or on a rising edge of `op_erase_busy` when erase suspend was low in the previous cycle. A read accepted in that same cycle reports 0 in both toggle positions. Resuming an erase from suspend keeps the toggles.
- R9: Program busy takes precedence over erase busy and erase suspend for busy-bank reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_bank | input | BANK_W | Bank addressed by the read |
| req_sector | input | SECT_W | Sector within the bank |
| req_array | input | DATA_W | Array data for the addressed location |
| op_prog_busy | input | 1 | Program algorithm running |
| op_erase_busy | input | 1 | Erase algorithm running |
| op_erase_susp | input | 1 | Erase suspended |
| op_timeout | input | 1 | Algorithm exceeded its time limit |
| busy_bank | input | BANK_W | Bank owning the algorithm |
| erase_sel | input | SECT_PER_BANK | Sectors selected for erase in the busy bank |
| erase_win_closed | input | 1 | Sector selection window has closed |
| last_wr_msb | input | 1 | Bit 7 of the last byte written |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read word |

## Verification
The hardest case to reach is a toggle sequence that a non-status read interleaves while the consumer stalls. An idle-bank read, an unselected-sector read, or a read that waits under back-pressure must leave both toggle bits where they were. The stimulus therefore mixes busy-bank, idle-bank and unselected-sector reads while a pseudo-random pattern drives `rsp_ready`, and it inserts a forced stall of several cycles. A second hard case is the pair of clear rules: a program started during suspend clears the toggles, and an erase resumed from suspend must not. The bench walks through suspend → program → suspend → resume and keeps comparing against the reference model.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [1:0] {
    OPM_IDLE  = 2'd0,
    OPM_PROG  = 2'd1,
    OPM_ERASE = 2'd2,
    OPM_SUSP  = 2'd3
  } esg_opmode_e;

  typedef enum logic [1:0] {
    RDC_ARRAY = 2'd0,
    RDC_PROG  = 2'd1,
    RDC_ERASE = 2'd2,
    RDC_SUSP  = 2'd3
  } esg_rdclass_e;

  localparam int unsigned POS_POLL  = 7;
  localparam int unsigned POS_TGL   = 6;
  localparam int unsigned POS_TMO   = 5;
  localparam int unsigned POS_WIN   = 3;
  localparam int unsigned POS_STGL  = 2;
endpackage

// File: rtl/esg_op_track.sv
module esg_op_track
  import esg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_busy,
  input  logic        erase_busy,
  input  logic        erase_susp,
  output esg_opmode_e mode,
  output logic        op_start
);
  logic prog_q, erase_q, susp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      prog_q  <= prog_busy;
      erase_q <= erase_busy;
      susp_q  <= erase_susp;
    end
  end

  // a resume from suspend is not a fresh erase
  assign op_start = (prog_busy & ~prog_q) | (erase_busy & ~erase_q & ~susp_q);

  always_comb begin
    if (prog_busy)       mode = OPM_PROG;
    else if (erase_busy) mode = OPM_ERASE;
    else if (erase_susp) mode = OPM_SUSP;
    else                 mode = OPM_IDLE;
  end

  // R9: program wins over any erase state
  p_prog_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> mode == OPM_PROG);
endmodule

// File: rtl/esg_sector_hit.sv
module esg_sector_hit #(
  parameter int unsigned SECT_PER_BANK = 8,
  localparam int unsigned SECT_W = (SECT_PER_BANK > 1) ? $clog2(SECT_PER_BANK) : 1
) (
  input  logic [SECT_W-1:0]        sector,
  input  logic [SECT_PER_BANK-1:0] sel_mask,
  output logic                     hit
);
  logic [SECT_PER_BANK-1:0] match;

  for (genvar g = 0; g < SECT_PER_BANK; g++) begin : g_sect
    assign match[g] = sel_mask[g] && (sector == SECT_W'(g));
  end

  assign hit = |match;
endmodule

// File: rtl/esg_toggle_pair.sv
module esg_toggle_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic adv_main,
  input  logic adv_sect,
  output logic tgl_main,
  output logic tgl_sect
);
  logic main_q, sect_q;

  // a start in the same cycle as a read presents the cleared value
  assign tgl_main = op_start ? 1'b0 : main_q;
  assign tgl_sect = op_start ? 1'b0 : sect_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= 1'b0;
      sect_q <= 1'b0;
    end else begin
      main_q <= tgl_main ^ adv_main;
      sect_q <= tgl_sect ^ adv_sect;
    end
  end

  p_clear_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !adv_main) |=> !main_q);
  p_clear_sect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !adv_sect) |=> !sect_q);
  p_flip_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && adv_main) |=> main_q != $past(main_q));
  p_keep_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !adv_main) |=> $stable(main_q));
  p_flip_sect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && adv_sect) |=> sect_q != $past(sect_q));
  p_keep_sect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !adv_sect) |=> $stable(sect_q));
endmodule

// File: rtl/esg_rsp_slot.sv
module esg_rsp_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/esg_status_gen.sv
module esg_status_gen
  import esg_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned SECT_PER_BANK = 8,
  parameter int unsigned DATA_W        = 8,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned SECT_W = (SECT_PER_BANK > 1) ? $clog2(SECT_PER_BANK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [SECT_W-1:0]        req_sector,
  input  logic [DATA_W-1:0]        req_array,
  input  logic                     op_prog_busy,
  input  logic                     op_erase_busy,
  input  logic                     op_erase_susp,
  input  logic                     op_timeout,
  input  logic [BANK_W-1:0]        busy_bank,
  input  logic [SECT_PER_BANK-1:0] erase_sel,
  input  logic                     erase_win_closed,
  input  logic                     last_wr_msb,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data
);
  esg_opmode_e  mode;
  esg_rdclass_e rclass;
  logic op_start, sect_hit, bank_hit, accept;
  logic adv_main, adv_sect, tgl_main, tgl_sect;
  logic [DATA_W-1:0] word;

  esg_op_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_busy  (op_prog_busy),
    .erase_busy (op_erase_busy),
    .erase_susp (op_erase_susp),
    .mode       (mode),
    .op_start   (op_start)
  );

  esg_sector_hit #(.SECT_PER_BANK(SECT_PER_BANK)) u_hit (
    .sector   (req_sector),
    .sel_mask (erase_sel),
    .hit      (sect_hit)
  );

  assign bank_hit = (req_bank == busy_bank);

  always_comb begin
    rclass = RDC_ARRAY;
    if (bank_hit) begin
      unique case (mode)
        OPM_PROG:  rclass = RDC_PROG;
        OPM_ERASE: rclass = RDC_ERASE;
        OPM_SUSP:  rclass = sect_hit ? RDC_SUSP : RDC_ARRAY;
        default:   rclass = RDC_ARRAY;
      endcase
    end
  end

  assign accept   = req_valid && req_ready;
  assign adv_main = accept && (rclass == RDC_PROG || rclass == RDC_ERASE);
  assign adv_sect = accept && ((rclass == RDC_ERASE && sect_hit) || rclass == RDC_SUSP);

  esg_toggle_pair u_tgl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .adv_main (adv_main),
    .adv_sect (adv_sect),
    .tgl_main (tgl_main),
    .tgl_sect (tgl_sect)
  );

  always_comb begin
    word = '0;
    unique case (rclass)
      RDC_PROG: begin
        word[POS_POLL] = ~last_wr_msb;
        word[POS_TGL]  = tgl_main;
        word[POS_TMO]  = op_timeout;
      end
      RDC_ERASE: begin
        word[POS_POLL] = 1'b0;
        word[POS_TGL]  = tgl_main;
        word[POS_TMO]  = op_timeout;
        word[POS_WIN]  = erase_win_closed;
        word[POS_STGL] = tgl_sect;
      end
      RDC_SUSP: begin
        word[POS_POLL] = 1'b1;
        word[POS_TGL]  = tgl_main;
        word[POS_STGL] = tgl_sect;
      end
      default: word = req_array;
    endcase
  end

  esg_rsp_slot #(.W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (word),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_data)
  );

  p_idle_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bank_hit) |=> rsp_data == $past(req_array));
  p_no_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_prog_busy && !op_erase_busy && !op_erase_susp) |=> rsp_data == $past(req_array));
  p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bank_hit && op_prog_busy) |=> rsp_data[POS_POLL] == !$past(last_wr_msb));
  p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bank_hit && op_erase_busy && !op_prog_busy) |=>
      (!rsp_data[POS_POLL] && rsp_data[POS_WIN] == $past(erase_win_closed)));
  p_susp_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bank_hit && sect_hit && op_erase_susp && !op_erase_busy && !op_prog_busy) |=>
      rsp_data[POS_POLL]);
endmodule

// File: tb/esg_status_gen_tb.sv
module esg_status_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [0:0] req_bank = '0;
  logic [2:0] req_sector = '0;
  logic [7:0] req_array = '0;
  logic op_prog_busy = 1'b0, op_erase_busy = 1'b0, op_erase_susp = 1'b0, op_timeout = 1'b0;
  logic [0:0] busy_bank = '0;
  logic [7:0] erase_sel = '0;
  logic erase_win_closed = 1'b0, last_wr_msb = 1'b0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0, bp_hold = 0, bp_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  bit m_valid, m_t6, m_t2, m_pp, m_pe, m_ps;
  logic [7:0] m_data;
  string m_tag = "R1";

  always #5 clk = ~clk;

  esg_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_sector(req_sector), .req_array(req_array),
    .op_prog_busy(op_prog_busy), .op_erase_busy(op_erase_busy),
    .op_erase_susp(op_erase_susp), .op_timeout(op_timeout), .busy_bank(busy_bank),
    .erase_sel(erase_sel), .erase_win_closed(erase_win_closed), .last_wr_msb(last_wr_msb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    bit acc, st, hit, selhit, adv6, adv2, t6e, t2e;
    logic [7:0] w;
    string tg;
    if (!rst_n) begin
      m_valid = 0; m_data = 0; m_t6 = 0; m_t2 = 0; m_pp = 0; m_pe = 0; m_ps = 0;
    end else begin
      acc = req_valid && (!m_valid || rsp_ready);
      st = (op_prog_busy && !m_pp) || (op_erase_busy && !m_pe && !m_ps);
      t6e = st ? 0 : m_t6;
      t2e = st ? 0 : m_t2;
      hit = (req_bank == busy_bank);
      selhit = erase_sel[req_sector];
      adv6 = 0; adv2 = 0;
      w = req_array; tg = "R2";
      if (hit && op_prog_busy) begin
        w = {~last_wr_msb, t6e, op_timeout, 5'b0}; tg = "R3/R5/R9"; adv6 = 1;
      end else if (hit && op_erase_busy) begin
        w = {1'b0, t6e, op_timeout, 1'b0, erase_win_closed, t2e, 2'b0}; tg = "R4/R5/R6";
        adv6 = 1; adv2 = selhit;
      end else if (hit && op_erase_susp && selhit) begin
        w = {1'b1, t6e, 3'b0, t2e, 2'b0}; tg = "R7/R6"; adv2 = 1;
      end else if (hit && op_erase_susp) tg = "R7";
      if (st) tg = {tg, "/R8"};
      if (acc) begin m_valid = 1; m_data = w; m_tag = tg; end
      else if (rsp_ready) m_valid = 0;
      m_t6 = t6e ^ (acc && adv6);
      m_t2 = t2e ^ (acc && adv2);
      m_pp = op_prog_busy; m_pe = op_erase_busy; m_ps = op_erase_susp;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (!m_valid || rsp_ready), "R1 req_ready", req_ready, !m_valid || rsp_ready);
      chk(rsp_valid == m_valid, "R1 rsp_valid", rsp_valid, m_valid);
      if (m_valid) chk(rsp_data == m_data, m_tag, rsp_data, m_data);
    end
  end

  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready = bp_hold ? 1'b0 : (bp_rand ? (lfsr[0] | lfsr[3]) : 1'b1);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic rd(input bit b, input int s, input logic [7:0] arr);
    bit rdy;
    @(negedge clk); #2;
    req_bank = b; req_sector = 3'(s); req_array = arr; req_valid = 1;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk); #2;
    end
    @(negedge clk); #2;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R2: nothing running
    rd(0, 1, 8'h3C); rd(1, 4, 8'hC3);
    // R3 R5: program in bank 0
    last_wr_msb = 1; busy_bank = 0; op_prog_busy = 1;
    rd(0, 0, 8'h11); rd(0, 2, 8'h22); rd(0, 0, 8'h33);
    rd(1, 0, 8'h44);          // idle bank must not disturb toggle
    rd(0, 5, 8'h55);
    op_timeout = 1; rd(0, 1, 8'h66); op_timeout = 0;
    op_prog_busy = 0; idle(1);
    rd(0, 0, 8'hA5);          // R2 completed: true data
    // R4 R6 R8: erase in bank 1, sectors 0 and 2
    busy_bank = 1; erase_sel = 8'b0000_0101; last_wr_msb = 0;
    bp_rand = 1;
    @(negedge clk); #2; op_erase_busy = 1;
    req_bank = 1; req_sector = 0; req_valid = 1; req_array = 8'hFF;
    @(posedge clk); @(negedge clk); #2; req_valid = 0;   // read in start cycle (R8)
    for (int i = 0; i < 12; i++) begin
      rd(i % 3 == 2 ? 1'b0 : 1'b1, i % 4, 8'(i * 29));
      if (i == 5) erase_win_closed = 1;
    end
    // R1 forced stall
    bp_hold = 1; rd(1, 0, 8'h00); idle(5); bp_hold = 0; idle(2);
    // R7: suspend
    op_erase_busy = 0; op_erase_susp = 1;
    for (int i = 0; i < 8; i++) rd(i[0], i % 4, 8'(8'h80 + i));
    // R9 + R8: program during suspend
    op_prog_busy = 1; last_wr_msb = 1;
    for (int i = 0; i < 5; i++) rd(1, i, 8'(i));
    op_prog_busy = 0; idle(1);
    rd(1, 0, 8'h7E); rd(1, 2, 8'h7F);
    // R8: resume keeps toggles
    op_erase_busy = 1; op_erase_susp = 0;
    for (int i = 0; i < 6; i++) rd(1, i, 8'(i + 9));
    op_erase_busy = 0; erase_sel = 0;
    rd(1, 0, 8'hFF);
    bp_rand = 0; idle(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule